// File: doc/BRIEF.md
# Dual-Clock FIFO Occupancy Threshold Flags

This block produces two programmable, active-low threshold flags for an asynchronous FIFO of depth `DEPTH` whose writes and reads run on unrelated clocks. It keeps its own write and read pointers, each `log2(DEPTH)+1` bits wide. It moves each pointer into the opposite clock domain as Gray code through a two-flop synchroniser. In each domain it compares the local pointer against the received remote pointer and registers the result on the local clock. The storage array, width conversion and runtime loading of the offsets belong to neighbouring blocks.

`almost_empty_n` lives on `rclk`. It is low while the FIFO holds `AE_OFS` or fewer words. `almost_full_n` lives on `wclk`. It is low while `DEPTH-AF_OFS` or more words are held. A local operation that moves the level into a flag's active region lowers that flag on the same local edge. An operation on the opposite side that moves the level out of the region raises the flag on the second local edge after it. When the two clock edges nearly coincide, this can take one more local edge.

There is no data path, so the block has no valid/ready interface. Both enables are plain strobes, sampled on the rising edge of their own clock. The neighbouring logic must not write into a full FIFO or read from an empty one, since the block has no back-pressure of its own.

Top module: `afifo_level_flags`

## Requirements
- R1: While `wrst_n` and `rrst_n` are held low and right after they are released, `almost_empty_n` is 0 and `almost_full_n` is 1.
- R2: Once the pointers have crossed, `almost_empty_n` is 0 when the FIFO holds at most `AE_OFS` words (default 8) and 1 when it holds `AE_OFS+1` or more.
- R3: Once the pointers have crossed, `almost_full_n` is 0 when the FIFO holds at least `DEPTH-AF_OFS` words (default 2048-8=2040) and 1 when it holds `DEPTH-AF_OFS-1` or fewer.
- R4: A read that brings the level down to `AE_OFS` drives `almost_empty_n` to 0 right after that same `rclk` rising edge.
- R5: A write that brings the level up to `DEPTH-AF_OFS` drives `almost_full_n` to 0 right after that same `wclk` rising edge.
- R6: A write that lifts the level from `AE_OFS` to `AE_OFS+1` leaves `almost_empty_n` at 0 after the first later `rclk` edge and raises it on the second, or the third when the edges are too close together. The pointer is sent across in Gray code, so it changes in only one bit per edge.
- R7: A read that drops the level from `DEPTH-AF_OFS` to one below it leaves `almost_full_n` at 0 after the first later `wclk` edge and raises it on the second, or the third when the edges are too close together.
- R8: A clock edge with `wr_en` or `rd_en` low does not change the level. The FIFO level never goes above `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_en | input | 1 | One word written on each rising `wclk` edge while high |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_en | input | 1 | One word read on each rising `rclk` edge while high |
| almost_empty_n | output | 1 | Low while level <= `AE_OFS`, on `rclk` |
| almost_full_n | output | 1 | Low while level >= `DEPTH-AF_OFS`, on `wclk` |

## Verification
The assertions assume that writes never push the level past `DEPTH` and that reads never take it below zero. They also assume that each enable is a clean level on its own clock, so the level seen against the delayed remote pointer stays in range. The stimulus models the level itself, issues only operations that keep it between 0 and `DEPTH`, and lets both synchronisers settle before it compares the flags. The two clocks use unrelated periods and phases, so every input change and every sample falls away from the edges of both clocks.

// File: rtl/afifo_flag_pkg.sv
package afifo_flag_pkg;
  typedef enum logic {
    SIDE_EMPTY = 1'b0,
    SIDE_FULL  = 1'b1
  } side_e;
endpackage

// File: rtl/afifo_ptr.sv
module afifo_ptr #(
  parameter int unsigned PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [PW-1:0] bin_next,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q
);
  always_comb bin_next = bin_q + PW'(en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_next;
      gray_q <= bin_next ^ (bin_next >> 1);
    end
  end

  // R6: the code that crosses domains moves by at most one bit per edge
  p_gray_onebit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int unsigned PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] s1_bin,
  output logic [PW-1:0] s2_bin
);
  logic [PW-1:0] s1_g, s2_g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_g <= '0;
      s2_g <= '0;
    end else begin
      s1_g <= gray_in;
      s2_g <= s1_g;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_dec
    assign s1_bin[i] = ^(s1_g >> i);
    assign s2_bin[i] = ^(s2_g >> i);
  end
endmodule

// File: rtl/afifo_flag.sv
module afifo_flag
  import afifo_flag_pkg::*;
#(
  parameter int unsigned PW    = 12,
  parameter side_e       SIDE  = SIDE_EMPTY,
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned OFS   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          local_op,
  input  logic [PW-1:0] local_cur,
  input  logic [PW-1:0] local_next,
  input  logic [PW-1:0] remote_s1,
  input  logic [PW-1:0] remote_s2,
  output logic          flag_n
);
  localparam logic [PW-1:0] LIMIT = (SIDE == SIDE_EMPTY) ? PW'(OFS) : PW'(DEPTH - OFS);
  localparam logic          RST_VAL = (SIDE == SIDE_FULL);

  function automatic logic [PW-1:0] level_of(input logic [PW-1:0] loc, input logic [PW-1:0] rem);
    return (SIDE == SIDE_EMPTY) ? (rem - loc) : (loc - rem);
  endfunction

  function automatic logic released(input logic [PW-1:0] lvl);
    return (SIDE == SIDE_EMPTY) ? (lvl > LIMIT) : (lvl < LIMIT);
  endfunction

  // The flag register doubles as the second capture of the remote pointer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_n <= RST_VAL;
    else        flag_n <= released(level_of(local_next, remote_s1));
  end

  // R2 / R3: the registered flag agrees with the level seen by the synchroniser
  p_flag_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_n == released(level_of(local_cur, remote_s2)));

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level_of(local_cur, remote_s2) <= PW'(DEPTH));

  // R4 / R5: only a local operation can move the flag into its active state
  p_fall_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_n) |-> $past(local_op));

  // R6 / R7: only fresh remote pointer movement can release the flag
  p_rise_remote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_n) |-> $past(remote_s1 != remote_s2));
endmodule

// File: rtl/afifo_level_flags.sv
module afifo_level_flags
  import afifo_flag_pkg::*;
#(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned AE_OFS = 8,
  parameter int unsigned AF_OFS = 8
) (
  input  logic wclk,
  input  logic wrst_n,
  input  logic wr_en,
  input  logic rclk,
  input  logic rrst_n,
  input  logic rd_en,
  output logic almost_empty_n,
  output logic almost_full_n
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wb_next, wb_q, wg_q;
  logic [PW-1:0] rb_next, rb_q, rg_q;
  logic [PW-1:0] w_in_r_s1, w_in_r_s2;
  logic [PW-1:0] r_in_w_s1, r_in_w_s2;

  afifo_ptr #(.PW(PW)) u_wptr (
    .clk(wclk), .rst_n(wrst_n), .en(wr_en),
    .bin_next(wb_next), .bin_q(wb_q), .gray_q(wg_q)
  );

  afifo_ptr #(.PW(PW)) u_rptr (
    .clk(rclk), .rst_n(rrst_n), .en(rd_en),
    .bin_next(rb_next), .bin_q(rb_q), .gray_q(rg_q)
  );

  afifo_sync #(.PW(PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .gray_in(wg_q),
    .s1_bin(w_in_r_s1), .s2_bin(w_in_r_s2)
  );

  afifo_sync #(.PW(PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .gray_in(rg_q),
    .s1_bin(r_in_w_s1), .s2_bin(r_in_w_s2)
  );

  afifo_flag #(.PW(PW), .SIDE(SIDE_EMPTY), .DEPTH(DEPTH), .OFS(AE_OFS)) u_ae (
    .clk(rclk), .rst_n(rrst_n), .local_op(rd_en),
    .local_cur(rb_q), .local_next(rb_next),
    .remote_s1(w_in_r_s1), .remote_s2(w_in_r_s2),
    .flag_n(almost_empty_n)
  );

  afifo_flag #(.PW(PW), .SIDE(SIDE_FULL), .DEPTH(DEPTH), .OFS(AF_OFS)) u_af (
    .clk(wclk), .rst_n(wrst_n), .local_op(wr_en),
    .local_cur(wb_q), .local_next(wb_next),
    .remote_s1(r_in_w_s1), .remote_s2(r_in_w_s2),
    .flag_n(almost_full_n)
  );
endmodule

// File: tb/sim_afifo_level_flags.sv
`timescale 1ns/100ps
module sim_afifo_level_flags;
  localparam int unsigned DEPTH = 2048;
  localparam int unsigned AE    = 8;
  localparam int unsigned AF    = 8;
  localparam int NV = 8;
  // {writes, reads, expected almost_empty_n, expected almost_full_n}
  localparam int VEC [NV][4] = '{
    '{8,    0,    0, 1},
    '{1,    0,    1, 1},
    '{0,    1,    0, 1},
    '{2031, 0,    1, 1},
    '{1,    0,    1, 0},
    '{0,    1,    1, 1},
    '{9,    0,    1, 0},
    '{0,    2048, 0, 1}
  };

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic almost_empty_n, almost_full_n;
  int total = 0, bad = 0;

  afifo_level_flags #(.DEPTH(DEPTH), .AE_OFS(AE), .AF_OFS(AF)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  always #4 wclk = ~wclk;
  initial begin
    #2.5;
    forever #5 rclk = ~rclk;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writes(input int n);
    if (n > 0) begin
      @(negedge wclk); wr_en = 1;
      repeat (n) @(negedge wclk);
      wr_en = 0;
    end
  endtask

  task automatic reads(input int n);
    if (n > 0) begin
      @(negedge rclk); rd_en = 1;
      repeat (n) @(negedge rclk);
      rd_en = 0;
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  task automatic one_write();
    @(negedge wclk); wr_en = 1;
    @(posedge wclk); #1 wr_en = 0;
  endtask

  task automatic one_read();
    @(negedge rclk); rd_en = 1;
    @(posedge rclk); #1 rd_en = 0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wclk);
    chk("R1 ae in reset", almost_empty_n, 1'b0);
    chk("R1 af in reset", almost_full_n, 1'b1);
    @(negedge wclk); wrst_n = 1;
    @(negedge rclk); rrst_n = 1;
    settle();
    chk("R1 ae after reset", almost_empty_n, 1'b0);
    chk("R1 af after reset", almost_full_n, 1'b1);

    for (int i = 0; i < NV; i++) begin
      writes(VEC[i][0]);
      reads(VEC[i][1]);
      settle();
      chk($sformatf("R2 vector %0d ae", i), almost_empty_n, VEC[i][2] != 0);
      chk($sformatf("R3 vector %0d af", i), almost_full_n, VEC[i][3] != 0);
    end

    // level 0 -> 9, then idle read clock must not drain it (R8)
    writes(9); settle();
    chk("R2 level 9 ae", almost_empty_n, 1'b1);
    repeat (50) @(negedge rclk);
    chk("R8 idle rclk keeps ae", almost_empty_n, 1'b1);
    // R4: a single read to level 8 asserts on that edge
    one_read();
    chk("R4 ae low on read edge", almost_empty_n, 1'b0);
    // R6: write to level 9 released on the second rclk edge
    one_write();
    @(posedge rclk); #1;
    chk("R6 ae still low after edge 1", almost_empty_n, 1'b0);
    @(posedge rclk); #1;
    chk("R6 ae high after edge 2", almost_empty_n, 1'b1);

    // level 9 -> 2039
    writes(2030); settle();
    chk("R3 level 2039 af", almost_full_n, 1'b1);
    repeat (50) @(negedge wclk);
    chk("R8 idle wclk keeps af", almost_full_n, 1'b1);
    // R5: a single write to level 2040 asserts on that edge
    one_write();
    chk("R5 af low on write edge", almost_full_n, 1'b0);
    // R7: read to level 2039 released on the second wclk edge
    one_read();
    @(posedge wclk); #1;
    chk("R7 af still low after edge 1", almost_full_n, 1'b0);
    @(posedge wclk); #1;
    chk("R7 af high after edge 2", almost_full_n, 1'b1);
    settle();
    chk("R2 level 2039 ae", almost_empty_n, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule